// File: doc/BRIEF.md
# Receive Frame Channel Steering Unit

This block sits behind the receive MAC and the CRC checker. It takes whole Ethernet frames from one byte stream and sends each frame to one of `NUM_CH` receive channels. The channel is taken from the remote end of the connection: the IPv4 source address and the transport source port are folded into a key. Because a stream to the same remote peer always lands on the same channel, per-connection ordering holds while the load spreads over the channels.

The first `MIN_LEN` bytes of each frame are held in a small header store until the block decides what to do with the frame. It then drops the frame or replays the stored bytes to the output and passes the rest of the frame straight through. A frame is dropped when it is too short, when it is addressed to another station, or when the selected channel reports that it has no free container. Five saturating counters record what happened to each frame, and one command pulse clears all of them. The local station address is a 48-bit register. It takes a new value only between frames.

Top module: `rxd_dispatch`

## Requirements
- R1: The output channel equals (S[31:16] XOR S[15:0] XOR P) modulo `NUM_CH`. S is the 32-bit source IP held big-endian in frame bytes 26 to 29, and P is the 16-bit source port held big-endian in bytes 34 and 35 (byte 0 is the first byte of the frame).
- R2: A frame that is kept appears on the output byte for byte, in its original order. `out_chan` is constant over the whole frame, `out_last` is set on the final byte only, and no byte is lost or repeated when `out_ready` is held low.
- R3: A frame whose destination address (bytes 0 to 5, byte 0 most significant) is neither the local address nor all ones produces no output. It raises `cnt_dst_drop` by one.
- R4: A frame sent to the all-ones destination is kept whatever the local address is.
- R5: When `ch_avail[channel]` is 0 in the decision cycle, the frame produces no output and `cnt_full_drop` rises by one.
- R6: A frame that ends before byte `MIN_LEN`-1 (42 bytes by default) produces no output and raises `cnt_short_drop`. A frame of exactly `MIN_LEN` bytes is kept.
- R7: `cnt_rx_total` rises by one for every frame that starts, and `cnt_fwd` rises by one for every frame that is kept. All counters read zero after reset.
- R8: A `cnt_clear` pulse sets every counter to zero on the next clock edge.
- R9: Each counter stops at 2^`CNT_W`-1 and holds that value while further events arrive.
- R10: `mac_load` writes `mac_value` into the local address only while no frame is in progress. A pulse that arrives in the middle of a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last of its frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Channel side accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Output byte is the last of its frame |
| out_chan | output | CH_W | Channel the current frame is steered to |
| ch_avail | input | NUM_CH | Per-channel flag: a free container exists |
| mac_load | input | 1 | Load the local station address |
| mac_value | input | 48 | New local station address |
| cnt_clear | input | 1 | Clear all counters |
| cnt_rx_total | output | CNT_W | Frames started |
| cnt_fwd | output | CNT_W | Frames kept |
| cnt_dst_drop | output | CNT_W | Frames dropped for destination address |
| cnt_full_drop | output | CNT_W | Frames dropped because the channel was full |
| cnt_short_drop | output | CNT_W | Frames dropped as too short |

## Verification
The key function is tried with several source address and port pairs whose fold lands on different channels. Each pair is predicted in the bench by a byte-wise XOR, which catches a swapped field, a wrong byte offset or a wrong reduction. Frames that differ only in their destination address (local, broadcast, foreign) separate the address filter from the channel check. A frame that fits a full channel and the same frame with `ch_avail` set show that the availability flag alone makes the difference. Frame lengths of 30, 41 and 42 bytes probe the short boundary. A frame of 100 bytes with a toggling `out_ready` exercises stalls in both the replay and the pass-through phases.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // frame byte offsets used by the steering decision
  localparam int DST_OFS  = 0;
  localparam int SIP_OFS  = 26;
  localparam int SPRT_OFS = 34;

  localparam logic [47:0] BCAST_MAC = 48'hFFFF_FFFF_FFFF;

  typedef enum logic [2:0] {
    ST_HDR    = 3'd0,
    ST_DECIDE = 3'd1,
    ST_REPLAY = 3'd2,
    ST_BODY   = 3'd3,
    ST_DROP   = 3'd4
  } rxd_state_e;

  // counter slots
  localparam int CNT_RX    = 0;
  localparam int CNT_FWD   = 1;
  localparam int CNT_DST   = 2;
  localparam int CNT_FULL  = 3;
  localparam int CNT_SHORT = 4;
  localparam int NUM_CNT   = 5;

  function automatic logic [15:0] key_fold(input logic [31:0] ip, input logic [15:0] port);
    return ip[31:16] ^ ip[15:0] ^ port;
  endfunction

endpackage

// File: rtl/rxd_sat_cnt.sv
module rxd_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= '0;
    else if (clr)          q <= '0;
    else if (inc && q != TOP) q <= q + 1'b1;
  end

  // R9
  stays_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == TOP && !clr) |=> q == TOP);

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> q >= $past(q));

endmodule

// File: rtl/rxd_chan_key.sv
module rxd_chan_key #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [31:0]     src_ip,
  input  logic [15:0]     src_port,
  output logic [CH_W-1:0] key
);

  localparam logic [15:0] MOD = 16'(NUM_CH);

  logic [15:0] fold;
  logic [15:0] rem;

  assign fold = rxd_pkg::key_fold(src_ip, src_port);
  assign rem  = fold % MOD;
  assign key  = rem[CH_W-1:0];

endmodule

// File: rtl/rxd_dispatch.sv
module rxd_dispatch #(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 42,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic [CH_W-1:0]   out_chan,
  input  logic [NUM_CH-1:0] ch_avail,
  input  logic              mac_load,
  input  logic [47:0]       mac_value,
  input  logic              cnt_clear,
  output logic [CNT_W-1:0]  cnt_rx_total,
  output logic [CNT_W-1:0]  cnt_fwd,
  output logic [CNT_W-1:0]  cnt_dst_drop,
  output logic [CNT_W-1:0]  cnt_full_drop,
  output logic [CNT_W-1:0]  cnt_short_drop
);

  import rxd_pkg::*;

  localparam int IDX_W = $clog2(MIN_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MIN_LEN - 1);

  rxd_state_e       st;
  logic [7:0]       hdr [MIN_LEN];
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             last_seen;
  logic [CH_W-1:0]  chan_q;
  logic [47:0]      local_mac;

  // header fields
  logic [47:0]     dst_mac;
  logic [31:0]     src_ip;
  logic [15:0]     src_port;
  logic [CH_W-1:0] key;
  logic            dst_ok;
  logic            avail;

  assign dst_mac  = {hdr[DST_OFS], hdr[DST_OFS+1], hdr[DST_OFS+2],
                     hdr[DST_OFS+3], hdr[DST_OFS+4], hdr[DST_OFS+5]};
  assign src_ip   = {hdr[SIP_OFS], hdr[SIP_OFS+1], hdr[SIP_OFS+2], hdr[SIP_OFS+3]};
  assign src_port = {hdr[SPRT_OFS], hdr[SPRT_OFS+1]};

  rxd_chan_key #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_key (
    .src_ip  (src_ip),
    .src_port(src_port),
    .key     (key)
  );

  assign dst_ok = (dst_mac == local_mac) || (dst_mac == BCAST_MAC);
  assign avail  = ch_avail[key];

  // named events
  logic in_fire, out_fire, idle;
  logic ev_start, ev_short, ev_hdr_done, ev_dst_drop, ev_full_drop, ev_fwd;

  assign in_fire     = in_valid && in_ready;
  assign out_fire    = out_valid && out_ready;
  assign idle        = (st == ST_HDR) && (wr_idx == '0);
  assign ev_start    = (st == ST_HDR) && in_fire && (wr_idx == '0);
  assign ev_hdr_done = (st == ST_HDR) && in_fire && (wr_idx == LAST_IDX);
  assign ev_short    = (st == ST_HDR) && in_fire && in_last && (wr_idx != LAST_IDX);
  assign ev_dst_drop = (st == ST_DECIDE) && !dst_ok;
  assign ev_full_drop= (st == ST_DECIDE) && dst_ok && !avail;
  assign ev_fwd      = (st == ST_DECIDE) && dst_ok && avail;

  always_comb begin
    case (st)
      ST_HDR, ST_DROP: in_ready = 1'b1;
      ST_BODY:         in_ready = out_ready;
      default:         in_ready = 1'b0;
    endcase
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = hdr[rd_idx];
    out_last  = 1'b0;
    if (st == ST_REPLAY) begin
      out_valid = 1'b1;
      out_last  = last_seen && (rd_idx == LAST_IDX);
    end else if (st == ST_BODY) begin
      out_valid = in_valid;
      out_data  = in_data;
      out_last  = in_last;
    end
  end

  assign out_chan = chan_q;

  always_ff @(posedge clk) begin
    if (st == ST_HDR && in_fire) hdr[wr_idx] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      wr_idx    <= '0;
      rd_idx    <= '0;
      last_seen <= 1'b0;
      chan_q    <= '0;
    end else begin
      case (st)
        ST_HDR: begin
          if (ev_hdr_done) begin
            wr_idx    <= '0;
            last_seen <= in_last;
            st        <= ST_DECIDE;
          end else if (ev_short) begin
            wr_idx <= '0;
          end else if (in_fire) begin
            wr_idx <= wr_idx + 1'b1;
          end
        end
        ST_DECIDE: begin
          if (ev_fwd) begin
            chan_q <= key;
            rd_idx <= '0;
            st     <= ST_REPLAY;
          end else begin
            st <= last_seen ? ST_HDR : ST_DROP;
          end
        end
        ST_REPLAY: begin
          if (out_fire) begin
            if (rd_idx == LAST_IDX) begin
              rd_idx <= '0;
              st     <= last_seen ? ST_HDR : ST_BODY;
            end else begin
              rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        ST_BODY: if (in_fire && in_last) st <= ST_HDR;
        ST_DROP: if (in_fire && in_last) st <= ST_HDR;
        default: st <= ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                local_mac <= '0;
    else if (mac_load && idle) local_mac <= mac_value;
  end

  // counter bank
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  assign cnt_inc[CNT_RX]    = ev_start;
  assign cnt_inc[CNT_FWD]   = ev_fwd;
  assign cnt_inc[CNT_DST]   = ev_dst_drop;
  assign cnt_inc[CNT_FULL]  = ev_full_drop;
  assign cnt_inc[CNT_SHORT] = ev_short;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rxd_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_clear),
      .inc  (cnt_inc[g]),
      .q    (cnt_q[g])
    );
  end

  assign cnt_rx_total   = cnt_q[CNT_RX];
  assign cnt_fwd        = cnt_q[CNT_FWD];
  assign cnt_dst_drop   = cnt_q[CNT_DST];
  assign cnt_full_drop  = cnt_q[CNT_FULL];
  assign cnt_short_drop = cnt_q[CNT_SHORT];

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |=> $stable(out_chan));

  // R2
  replay_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REPLAY && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  dst_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dst_drop |=> !out_valid);

  // R5
  full_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DECIDE) && !ch_avail[key]) |=> !out_valid);

  // R10
  mac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(local_mac));

endmodule

// File: tb/rxd_dispatch_tb.sv
module rxd_dispatch_tb;

  localparam int NUM_CH  = 4;
  localparam int CNT_W   = 4;
  localparam int MIN_LEN = 42;
  localparam int CH_W    = 2;
  localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic [CH_W-1:0] out_chan;
  logic [NUM_CH-1:0] ch_avail = '1;
  logic mac_load = 1'b0, cnt_clear = 1'b0;
  logic [47:0] mac_value = '0;
  logic [CNT_W-1:0] c_rx, c_fwd, c_dst, c_full, c_short;

  always #10 clk = ~clk;

  rxd_dispatch #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_chan(out_chan), .ch_avail(ch_avail),
    .mac_load(mac_load), .mac_value(mac_value), .cnt_clear(cnt_clear),
    .cnt_rx_total(c_rx), .cnt_fwd(c_fwd), .cnt_dst_drop(c_dst),
    .cnt_full_drop(c_full), .cnt_short_drop(c_short)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit stall  = 1'b0;

  logic [7:0] frm [2048];
  int         flen;
  logic [7:0] got [2048];
  int         got_n = 0;
  int         got_frames = 0;
  int         got_last_n = 0;
  logic [CH_W-1:0] got_chan = '0;
  bit         chan_moved = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // output monitor, 2 ns before the rising edge
  initial forever begin
    @(negedge clk); #8;
    if (out_valid && out_ready) begin
      if (got_n > 0 && out_chan != got_chan) chan_moved = 1'b1;
      got[got_n] = out_data;
      got_chan   = out_chan;
      got_n++;
      if (out_last) begin got_frames++; got_last_n = got_n; end
    end
  end

  initial forever begin
    @(negedge clk); #1;
    out_ready = stall ? ~out_ready : 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int exp_key();
    logic [7:0] hi, lo;
    hi = frm[26] ^ frm[28] ^ frm[34];
    lo = frm[27] ^ frm[29] ^ frm[35];
    return int'({hi, lo}) % NUM_CH;
  endfunction

  task automatic build(input logic [47:0] dst, input logic [31:0] ip,
                       input logic [15:0] port, input int len);
    flen = len;
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 6; i++) frm[i] = dst[47 - 8*i -: 8];
    for (int i = 0; i < 4; i++) frm[26 + i] = ip[31 - 8*i -: 8];
    frm[34] = port[15:8];
    frm[35] = port[7:0];
  endtask

  task automatic send(input int mac_at, input logic [47:0] mval);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk); #1;
      in_valid  = 1'b1;
      in_data   = frm[i];
      in_last   = (i == flen - 1);
      mac_load  = (i == mac_at);
      mac_value = mval;
      #1;
      while (!in_ready) begin @(negedge clk); #2; end
    end
    @(negedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; mac_load = 1'b0;
    repeat (MIN_LEN + 10) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); #1; cnt_clear = 1'b1;
    @(negedge clk); #1; cnt_clear = 1'b0;
    got_n = 0; got_frames = 0; got_last_n = 0; chan_moved = 1'b0;
  endtask

  task automatic load_mac(input logic [47:0] m);
    @(negedge clk); #1; mac_load = 1'b1; mac_value = m;
    @(negedge clk); #1; mac_load = 1'b0;
  endtask

  task automatic check_payload(input string rq);
    int bad = 0;
    for (int i = 0; i < flen; i++) if (got[i] !== frm[i]) bad++;
    chk(got_n == flen, rq, got_n, flen);
    chk(bad == 0, rq, bad, 0);
    chk(got_last_n == flen, rq, got_last_n, flen);
  endtask

  task automatic t_reset();
    chk(c_rx == 0 && c_fwd == 0 && c_dst == 0 && c_full == 0 && c_short == 0,
        "R7 reset counters", c_rx + c_fwd + c_dst + c_full + c_short, 0);
    chk(out_valid == 1'b0, "R2 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R2 reset in_ready", in_ready, 1);
  endtask

  task automatic t_forward_basic();
    clear_all();
    build(MY_MAC, 32'h0A00_0001, 16'd80, 60);
    send(-1, '0);
    check_payload("R2 basic frame");
    chk(int'(got_chan) == exp_key(), "R1 basic key", got_chan, exp_key());
    chk(c_rx == 1, "R7 rx total", c_rx, 1);
    chk(c_fwd == 1, "R7 forwarded", c_fwd, 1);
  endtask

  task automatic t_keys();
    logic [31:0] ips [4] = '{32'hC0A8_0102, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_0003};
    logic [15:0] prt [4] = '{16'h1F90, 16'hABCD, 16'h0001, 16'h0000};
    for (int k = 0; k < 4; k++) begin
      clear_all();
      build(MY_MAC, ips[k], prt[k], 50);
      send(-1, '0);
      chk(got_frames == 1, "R1 key frame out", got_frames, 1);
      chk(int'(got_chan) == exp_key(), "R1 key value", got_chan, exp_key());
    end
  endtask

  task automatic t_bcast();
    clear_all();
    build(48'hFFFF_FFFF_FFFF, 32'h0102_0304, 16'h0506, 48);
    send(-1, '0);
    check_payload("R4 broadcast kept");
    chk(c_fwd == 1, "R4 broadcast count", c_fwd, 1);
  endtask

  task automatic t_dst_fail();
    clear_all();
    build(48'h02_11_22_33_44_56, 32'h0102_0304, 16'h0506, 64);
    send(-1, '0);
    chk(got_n == 0, "R3 foreign no output", got_n, 0);
    chk(c_dst == 1, "R3 dst drop count", c_dst, 1);
    chk(c_fwd == 0, "R3 not forwarded", c_fwd, 0);
  endtask

  task automatic t_ch_full();
    int k;
    clear_all();
    build(MY_MAC, 32'h0A0B_0C0D, 16'h0E0F, 56);
    k = exp_key();
    @(negedge clk); #1; ch_avail = '1; ch_avail[k] = 1'b0;
    send(-1, '0);
    chk(got_n == 0, "R5 full no output", got_n, 0);
    chk(c_full == 1, "R5 full count", c_full, 1);
    @(negedge clk); #1; ch_avail = '0; ch_avail[k] = 1'b1;
    send(-1, '0);
    chk(got_frames == 1, "R5 only own flag matters", got_frames, 1);
    chk(c_full == 1, "R5 full count unchanged", c_full, 1);
    @(negedge clk); #1; ch_avail = '1;
  endtask

  task automatic t_short();
    clear_all();
    build(MY_MAC, 32'h1111_2222, 16'h3333, 30);
    send(-1, '0);
    build(MY_MAC, 32'h1111_2222, 16'h3333, 41);
    send(-1, '0);
    chk(got_n == 0, "R6 short no output", got_n, 0);
    chk(c_short == 2, "R6 short count", c_short, 2);
    build(MY_MAC, 32'h1111_2222, 16'h3333, 42);
    send(-1, '0);
    check_payload("R6 minimum frame kept");
    chk(c_rx == 3, "R7 rx total short mix", c_rx, 3);
  endtask

  task automatic t_backpressure();
    clear_all();
    stall = 1'b1;
    build(MY_MAC, 32'hDEAD_BEEF, 16'h4242, 100);
    send(-1, '0);
    stall = 1'b0;
    repeat (4) @(negedge clk);
    check_payload("R2 stalled frame");
    chk(chan_moved == 1'b0, "R2 chan steady", chan_moved, 0);
  endtask

  task automatic t_clear();
    build(MY_MAC, 32'h0, 16'h0, 10);
    send(-1, '0);
    chk(c_rx != 0, "R8 pre-clear nonzero", c_rx, 1);
    clear_all();
    chk(c_rx == 0 && c_short == 0 && c_fwd == 0, "R8 cleared",
        c_rx + c_short + c_fwd, 0);
  endtask

  task automatic t_sat();
    clear_all();
    build(MY_MAC, 32'h0, 16'h0, 10);
    for (int i = 0; i < 17; i++) send(-1, '0);
    chk(c_rx == 15, "R9 rx saturate", c_rx, 15);
    chk(c_short == 15, "R9 short saturate", c_short, 15);
  endtask

  task automatic t_mac();
    logic [47:0] other = 48'h0A_0B_0C_0D_0E_0F;
    clear_all();
    build(MY_MAC, 32'h5555_AAAA, 16'h1234, 50);
    send(5, other);
    chk(got_frames == 1, "R10 mid-frame load ignored", got_frames, 1);
    clear_all();
    send(-1, '0);
    chk(got_frames == 1, "R10 old address still local", got_frames, 1);
    load_mac(other);
    clear_all();
    send(-1, '0);
    chk(c_dst == 1, "R10 idle load takes effect", c_dst, 1);
    build(other, 32'h5555_AAAA, 16'h1234, 50);
    send(-1, '0);
    chk(got_frames == 1, "R10 new address kept", got_frames, 1);
    load_mac(MY_MAC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    load_mac(MY_MAC);
    t_forward_basic();
    t_keys();
    t_bcast();
    t_dst_fail();
    t_ch_full();
    t_short();
    t_backpressure();
    t_clear();
    t_sat();
    t_mac();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule